// File: doc/BRIEF.md
# UART Receive FIFO with Status Flags

This block sits between a UART deserializer and the host bus. Each received character arrives as a one-cycle strobe with its byte and its framing and parity error bits. The block stores the character and its error bits in a 16-entry FIFO. It keeps the status flags that host software polls, and it raises a receive interrupt when the FIFO fill reaches a programmable trigger level. Bit sampling and baud generation are not part of this block.

Software uses a four-register port with single-cycle read and write strobes. Address 0 returns the byte at the head of the FIFO, and a read there pops it. Address 1 holds the data-ready, trigger, break and error flags, together with the error bits of the head entry. Address 2 holds the overrun flag and a live copy of the receive line, so software can confirm a break. Address 3 returns the fill count. A flag is cleared by a read that sees it at 1, followed by a write of 0 to its bit.

Top module: `uart_rxs_top`

## Requirements
- R1: The fill count on `fifo_count`, and in the low bits of register 3, starts at 0 after reset. It rises by one for each character accepted while `rx_en` is 1 and the FIFO holds fewer than 16 entries.
- R2: A read of register 0 returns the head byte and pops it, so bytes come out in arrival order. A read of register 0 while the FIFO is empty returns the last byte popped and leaves the count at 0.
- R3: A character that arrives while 16 entries are held is dropped and leaves the stored contents unchanged. It sets the overrun flag, which is bit 0 of register 2.
- R4: The trigger flag (register 1, bit 1) sets on the cycle after the count is at or above the trigger level. `trig_sel` values 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R5: `rx_irq` is high for exactly one cycle, the first cycle in which the trigger flag reads 1 after reading 0.
- R6: A flag clears only when a write of 0 to its bit follows a read of its register that saw the flag at 1. A write of 0 without that read, or a write of 1, leaves the flag set. A set condition present in the same cycle wins over the clear.
- R7: The error flag (register 1, bit 3) sets while the head entry carries a framing or parity error. Bits 4 and 5 of register 1 show the head entry's framing and parity error bits.
- R8: A character with a framing error and an all-zero byte sets the break flag (register 1, bit 2). Bit 1 of register 2 always reflects `line_level`.
- R9: The data-ready flag (register 1, bit 0) sets once the FIFO has held between 1 and trigger-minus-one characters for `idle_limit` consecutive cycles with no new character. It sets once per idle period, and `idle_limit` of 0 disables it.
- R10: While `rx_en` is 0, incoming characters are ignored and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| char_valid | input | 1 | One-cycle strobe per received character |
| char_data | input | 8 | Received byte |
| char_ferr | input | 1 | Framing error of this character |
| char_perr | input | 1 | Parity error of this character |
| line_level | input | 1 | Current receive-line level |
| trig_sel | input | 2 | Trigger level select (1/4/8/14) |
| idle_limit | input | IDLE_W | Idle cycles before data-ready |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| fifo_count | output | CW | Current fill count |
| flag_dr | output | 1 | Data-ready flag |
| flag_rdf | output | 1 | Trigger-level flag |
| flag_brk | output | 1 | Break flag |
| flag_er | output | 1 | Receive error flag |
| flag_ovr | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
A bad read or write pointer shows on the next read of register 0 as a byte out of order. A bad count shows on `fifo_count` on the clock edge after the push or pop that caused it. A flag cell that arms wrongly shows as a flag that stays set, or clears, on the edge after the write of 0. A bad idle counter moves the data-ready edge away from exactly `idle_limit` cycles after the last character. The reference model is compared every cycle, so each of these faults is reported within one clock of first showing at a port.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    typedef struct packed {
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        RA_DATA  = 2'd0,
        RA_STAT  = 2'd1,
        RA_LINE  = 2'd2,
        RA_COUNT = 2'd3
    } reg_addr_e;

    localparam int NUM_FLAGS = 5;
    localparam int FL_DR  = 0;
    localparam int FL_RDF = 1;
    localparam int FL_BRK = 2;
    localparam int FL_ER  = 3;
    localparam int FL_OVR = 4;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  logic      pop,
    input  rx_entry_t din,
    output rx_entry_t head,
    output logic [CW-1:0] count,
    output logic      full,
    output logic      empty
);
    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxs_flag.sv
module rxs_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q_o
);
    logic armed;
    logic clr;

    assign clr = wr_i && !wbit_i && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o   <= 1'b0;
            armed <= 1'b0;
        end else begin
            q_o <= set_i | (q_o & ~clr);
            if (rd_i && q_o)  armed <= 1'b1;
            else if (wr_i)    armed <= 1'b0;
        end
    end
endmodule

// File: rtl/rxs_idle.sv
module rxs_idle #(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [IDLE_W-1:0] limit,
    output logic              fire
);
    logic [IDLE_W-1:0] cnt;

    assign fire = active && (limit != '0) &&
                  ((IDLE_W+1)'(cnt) + 1'b1 == (IDLE_W+1)'(limit));

    always_ff @(posedge clk) begin
        if (rst || !active)  cnt <= '0;
        else if (cnt < limit) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_rxs_top.sv
module uart_rxs_top
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int IDLE_W = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              char_valid,
    input  logic [7:0]        char_data,
    input  logic              char_ferr,
    input  logic              char_perr,
    input  logic              line_level,
    input  logic [1:0]        trig_sel,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [CW-1:0]     fifo_count,
    output logic              flag_dr,
    output logic              flag_rdf,
    output logic              flag_brk,
    output logic              flag_er,
    output logic              flag_ovr,
    output logic              rx_irq
);
    rx_entry_t   in_ent, head;
    logic        full, empty;
    logic        push_req, accept, pop;
    logic        idle_act, idle_fire;
    logic        head_err, head_ferr, head_perr;
    logic [7:0]  last_pop;
    logic        rdf_d;
    int unsigned trig;
    logic [NUM_FLAGS-1:0] fl_set, fl_q;

    assign in_ent   = '{ferr: char_ferr, perr: char_perr, data: char_data};
    assign push_req = char_valid && rx_en;
    assign accept   = push_req && !full;
    assign pop      = reg_rd && (reg_addr == RA_DATA) && !empty;
    assign trig     = trig_level(trig_sel);

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (accept),
        .pop   (pop),
        .din   (in_ent),
        .head  (head),
        .count (fifo_count),
        .full  (full),
        .empty (empty)
    );

    assign head_ferr = !empty && head.ferr;
    assign head_perr = !empty && head.perr;
    assign head_err  = head_ferr || head_perr;
    assign idle_act  = !empty && (32'(fifo_count) < trig) && !push_req;

    rxs_idle #(.IDLE_W(IDLE_W)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .active (idle_act),
        .limit  (idle_limit),
        .fire   (idle_fire)
    );

    always_comb begin
        fl_set         = '0;
        fl_set[FL_DR]  = idle_fire;
        fl_set[FL_RDF] = (32'(fifo_count) >= trig);
        fl_set[FL_BRK] = push_req && char_ferr && (char_data == 8'h00);
        fl_set[FL_ER]  = head_err;
        fl_set[FL_OVR] = push_req && full;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam reg_addr_e FA  = (i == FL_OVR) ? RA_LINE : RA_STAT;
        localparam int        FB  = (i == FL_OVR) ? 0 : i;
        rxs_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (fl_set[i]),
            .rd_i   (reg_rd && (reg_addr == FA)),
            .wr_i   (reg_wr && (reg_addr == FA)),
            .wbit_i (reg_wdata[FB]),
            .q_o    (fl_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pop <= '0;
            rdf_d    <= 1'b0;
        end else begin
            if (pop) last_pop <= head.data;
            rdf_d <= fl_q[FL_RDF];
        end
    end

    assign flag_dr  = fl_q[FL_DR];
    assign flag_rdf = fl_q[FL_RDF];
    assign flag_brk = fl_q[FL_BRK];
    assign flag_er  = fl_q[FL_ER];
    assign flag_ovr = fl_q[FL_OVR];
    assign rx_irq   = fl_q[FL_RDF] && !rdf_d;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_DATA:  reg_rdata = empty ? last_pop : head.data;
            RA_STAT:  reg_rdata = {2'b00, head_perr, head_ferr, fl_q[3:0]};
            RA_LINE:  reg_rdata = {6'b0, line_level, fl_q[FL_OVR]};
            default:  reg_rdata = 8'(fifo_count);
        endcase
    end
endmodule

// File: rtl/uart_rxs_chk.sv
module uart_rxs_chk
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          char_valid,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [1:0]    trig_sel,
    input logic [CW-1:0] fifo_count,
    input logic          flag_rdf,
    input logic          flag_ovr,
    input logic          rx_irq
);
    logic push_req, pop_req;
    assign push_req = char_valid && rx_en;
    assign pop_req  = reg_rd && (reg_addr == RA_DATA);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        32'(fifo_count) <= DEPTH);

    assert_pop_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (pop_req && fifo_count != '0 && !push_req) |=>
        fifo_count == CW'($past(fifo_count) - 1'b1));

    assert_ovr_on_full_R3: assert property (@(posedge clk) disable iff (rst)
        (push_req && 32'(fifo_count) == DEPTH) |=> flag_ovr);

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (push_req && 32'(fifo_count) == DEPTH && !pop_req) |=> 32'(fifo_count) == DEPTH);

    assert_rdf_level_R4: assert property (@(posedge clk) disable iff (rst)
        (32'(fifo_count) >= trig_level(trig_sel)) |=> flag_rdf);

    assert_irq_edge_R5: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (flag_rdf && !$past(flag_rdf)));

    assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !pop_req) |=> $stable(fifo_count));
endmodule

bind uart_rxs_top uart_rxs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .char_valid (char_valid),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .trig_sel   (trig_sel),
    .fifo_count (fifo_count),
    .flag_rdf   (flag_rdf),
    .flag_ovr   (flag_ovr),
    .rx_irq     (rx_irq)
);

// File: tb/uart_rxs_top_tb.sv
module uart_rxs_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int IDLE_W = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 0, rst = 1;
    logic rx_en = 0, char_valid = 0, char_ferr = 0, char_perr = 0, line_level = 1;
    logic [7:0] char_data = 0;
    logic [1:0] trig_sel = 0;
    logic [IDLE_W-1:0] idle_limit = 0;
    logic reg_rd = 0, reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic [CW-1:0] fifo_count;
    logic flag_dr, flag_rdf, flag_brk, flag_er, flag_ovr, rx_irq;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rxs_top #(.DEPTH(DEPTH), .IDLE_W(IDLE_W)) u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .char_valid(char_valid),
        .char_data(char_data), .char_ferr(char_ferr), .char_perr(char_perr),
        .line_level(line_level), .trig_sel(trig_sel), .idle_limit(idle_limit),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_count(fifo_count), .flag_dr(flag_dr),
        .flag_rdf(flag_rdf), .flag_brk(flag_brk), .flag_er(flag_er),
        .flag_ovr(flag_ovr), .rx_irq(rx_irq)
    );

    // ---------------- reference model ----------------
    bit [9:0] mq[$];          // {ferr, perr, data}
    bit       mf[5];          // DR, RDF, BRK, ER, OVR
    bit       marm[5];
    bit       mset[5];
    bit       m_rdf_prev;
    bit [7:0] m_last;
    int       m_idle;

    function automatic int tl(input logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int f = 0; f < 5; f++) begin mf[f] = 0; marm[f] = 0; end
            m_rdf_prev = 0; m_last = 0; m_idle = 0;
        end else begin
            int n, tr, ra, bn;
            bit push, act, clr;
            bit [9:0] hd;
            n  = mq.size();
            tr = tl(trig_sel);
            push = char_valid && rx_en;
            hd = (n > 0) ? mq[0] : 10'd0;
            act = (n > 0) && (n < tr) && !push;
            mset[0] = act && idle_limit != 0 && (m_idle + 1 == int'(idle_limit));
            mset[1] = (n >= tr);
            mset[2] = push && char_ferr && char_data == 8'h00;
            mset[3] = (n > 0) && (hd[9] || hd[8]);
            mset[4] = push && (n == DEPTH);
            if (!act) m_idle = 0;
            else if (m_idle < int'(idle_limit)) m_idle++;
            m_rdf_prev = mf[1];
            for (int f = 0; f < 5; f++) begin
                ra = (f < 4) ? 1 : 2;
                bn = (f < 4) ? f : 0;
                clr = reg_wr && reg_addr == ra && !reg_wdata[bn] && marm[f];
                if (reg_rd && reg_addr == ra && mf[f]) marm[f] = 1;
                else if (reg_wr && reg_addr == ra) marm[f] = 0;
                mf[f] = mset[f] | (mf[f] & !clr);
            end
            if (reg_rd && reg_addr == 0 && n > 0) begin
                m_last = mq[0][7:0];
                void'(mq.pop_front());
            end
            if (push && n < DEPTH) mq.push_back({char_ferr, char_perr, char_data});
        end
    end

    function automatic bit [7:0] m_rdata(input logic [1:0] a);
        bit [9:0] hd;
        hd = (mq.size() > 0) ? mq[0] : 10'd0;
        case (a)
            2'd0: return (mq.size() > 0) ? hd[7:0] : m_last;
            2'd1: return {2'b00, hd[8], hd[9], mf[3], mf[2], mf[1], mf[0]};
            2'd2: return {6'b0, line_level, mf[4]};
            default: return 8'(mq.size());
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 count", int'(fifo_count), mq.size());
            chk("R9 data-ready", flag_dr, mf[0]);
            chk("R4 trigger flag", flag_rdf, mf[1]);
            chk("R8 break", flag_brk, mf[2]);
            chk("R7 error", flag_er, mf[3]);
            chk("R3 overrun", flag_ovr, mf[4]);
            chk("R5 irq", rx_irq, mf[1] & !m_rdf_prev);
        end
    end

    // ---------------- stimulus tasks (enter at a negedge) ----------------
    task automatic rd_reg(input logic [1:0] a, input string tag, output logic [7:0] v);
        reg_rd = 1; reg_addr = a;
        #1;
        v = reg_rdata;
        chk(tag, reg_rdata, m_rdata(a));
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic push_ch(input logic [7:0] d, input logic fe, input logic pe);
        char_valid = 1; char_data = d; char_ferr = fe; char_perr = pe;
        @(negedge clk);
        char_valid = 0; char_ferr = 0; char_perr = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_cyc(3);
        rst = 0;
        // reset state (R1)
        rd_reg(2'd3, "R1 reset count", v);  chk("R1 reset count", v, 0);
        rd_reg(2'd1, "R6 reset status", v); chk("R6 reset status", v, 0);

        // data-ready after idle interval (R9), clear rules (R6)
        rx_en = 1; trig_sel = 2'd1; idle_limit = 8'd5;
        push_ch(8'hA1, 0, 0); push_ch(8'hB2, 0, 0); push_ch(8'hC3, 0, 0);
        rd_reg(2'd3, "R1 count after 3", v); chk("R1 count after 3", v, 3);
        wait_cyc(8);
        chk("R9 dr after idle", flag_dr, 1);
        wr_reg(2'd1, 8'h00);
        chk("R6 write0 without read keeps flag", flag_dr, 1);
        rd_reg(2'd1, "R6 status read", v);
        wr_reg(2'd1, 8'hFF);
        chk("R6 write1 keeps flag", flag_dr, 1);
        rd_reg(2'd1, "R6 status read", v);
        wr_reg(2'd1, 8'hFE);
        chk("R6 read then write0 clears", flag_dr, 0);

        // ordered pops and empty read (R2)
        rd_reg(2'd0, "R2 pop", v); chk("R2 first byte", v, 8'hA1);
        rd_reg(2'd0, "R2 pop", v); chk("R2 second byte", v, 8'hB2);
        rd_reg(2'd0, "R2 pop", v); chk("R2 third byte", v, 8'hC3);
        rd_reg(2'd0, "R2 empty read", v); chk("R2 empty read last", v, 8'hC3);
        chk("R2 count stays 0", fifo_count, 0);

        // trigger level 4 and interrupt (R4, R5)
        for (int i = 0; i < 4; i++) push_ch(8'h10 + 8'(i), 0, 0);
        chk("R4 count reached 4", fifo_count, 4);
        @(negedge clk);
        chk("R4 trigger flag set", flag_rdf, 1);
        chk("R5 irq pulse", rx_irq, 1);
        @(negedge clk);
        chk("R5 irq one cycle", rx_irq, 0);

        // fill and overrun (R3)
        trig_sel = 2'd3;
        for (int i = 0; i < 12; i++) push_ch(8'h20 + 8'(i), 0, 0);
        chk("R3 full count", fifo_count, 16);
        push_ch(8'h55, 0, 0);
        chk("R3 overrun set", flag_ovr, 1);
        chk("R3 count unchanged", fifo_count, 16);
        rd_reg(2'd2, "R3 line reg", v); chk("R3 ovr bit", v[0], 1);
        wr_reg(2'd2, 8'h00);
        chk("R3 ovr cleared", flag_ovr, 0);
        for (int i = 0; i < 16; i++) begin
            rd_reg(2'd0, "R3 drain", v);
            if (i == 0)  chk("R3 head kept", v, 8'h10);
            if (i == 15) chk("R3 tail not overwritten", v, 8'h2B);
        end

        // clear the trigger flag with FIFO empty (R6)
        rd_reg(2'd1, "R6 status read", v);
        wr_reg(2'd1, 8'h00);
        chk("R6 rdf cleared", flag_rdf, 0);

        // head error bits (R7)
        trig_sel = 2'd2;
        push_ch(8'h11, 0, 1); push_ch(8'h22, 0, 0);
        chk("R7 error flag", flag_er, 1);
        rd_reg(2'd1, "R7 status", v); chk("R7 head perr bit", v[5], 1);
        rd_reg(2'd0, "R7 pop bad", v); chk("R7 popped", v, 8'h11);
        rd_reg(2'd1, "R7 status after pop", v); chk("R7 head clean", v[5:4], 0);
        wr_reg(2'd1, 8'h00);
        chk("R7 error cleared", flag_er, 0);
        rd_reg(2'd0, "R7 pop", v);

        // break and line copy (R8)
        line_level = 0;
        push_ch(8'h00, 1, 0);
        chk("R8 break set", flag_brk, 1);
        rd_reg(2'd2, "R8 line low", v); chk("R8 line bit low", v[1], 0);
        line_level = 1;
        rd_reg(2'd2, "R8 line high", v); chk("R8 line bit high", v[1], 1);
        rd_reg(2'd1, "R8 head ferr", v); chk("R8 head ferr bit", v[4], 1);
        rd_reg(2'd0, "R8 pop", v);

        // receive disabled (R10)
        rx_en = 0;
        push_ch(8'h77, 0, 0);
        chk("R10 ignored", fifo_count, 0);
        wait_cyc(2);
        chk("R10 still ignored", fifo_count, 0);
        rx_en = 1;

        // trigger level 1 (R4, R5)
        rd_reg(2'd1, "R6 status read", v);
        wr_reg(2'd1, 8'h00);
        trig_sel = 2'd0;
        push_ch(8'h5A, 0, 0);
        @(negedge clk);
        chk("R4 level1 flag", flag_rdf, 1);
        chk("R5 level1 irq", rx_irq, 1);
        wait_cyc(3);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule